// File: doc/BRIEF.md
# PCM Serial Voice Port

This block is a frame-synchronous serial port that moves one voice sample in each direction per frame. An external bit clock times it, and it runs directly in that clock's domain. A frame-sync input, sampled on a rising edge, opens each frame. The transmit side shifts a word out on a dedicated serial output, most significant bit first. The receive side collects a word from a separate serial input in the same bit slots.

A two-bit format input selects the word layout for each frame. The choices are a 15-bit two's-complement linear word, an 8-bit µ-law code or an 8-bit A-law code. On the parallel side the port always deals in 15-bit linear samples. Transmit samples are compressed to the selected code when a frame starts. Received codes are expanded back to linear, left-aligned so that full scale matches the linear format. A transmit sample enters a holding register through a valid strobe. A received sample leaves with a one-cycle valid pulse. The bit clock is supplied from outside, and no filtering is done.

Top module: `pcm_voice_port`

## Requirements
- R1: While reset is held and after it is released with no frame sync, `sdout`, `rx_valid` and `rx_sample` are all zero.
- R2: The format input is sampled on the same rising edge that sees frame sync and holds for that frame. Code 00 and code 11 select 15-bit linear frames. Code 01 selects 8-bit µ-law frames and code 10 selects 8-bit A-law frames.
- R3: If frame sync is high at rising edge k, the frame's word appears on `sdout` MSB first. Bit j (j = 0 is the MSB) is driven from edge k+j until edge k+j+1, for N bits, where N is 15 or 8.
- R4: From edge k+N until the next edge that sees frame sync, `sdout` is 0.
- R5: `sdin` is sampled on edges k+1 through k+N, MSB first. The decoded sample appears on `rx_sample`, together with a `rx_valid` pulse lasting exactly one cycle, after edge k+N+1. `rx_sample` then holds until the next pulse.
- R6: `tx_valid` high at an edge loads `tx_sample` into a holding register. The holding register is converted and copied into the shifter on the frame-sync edge. A load during a frame changes only the word of the next frame.
- R7: µ-law transmit works as follows. The magnitude of the sample is clamped to 16383 and halved. It is then clamped to 8158 and 33 is added. The segment is the position of the highest set bit minus 5. The mantissa is the four bits below that set bit. The code is the bitwise inverse of {sign, segment, mantissa}, where the sign is 1 for negative samples. This code fills word bits 7..0 and is sent MSB first.
- R8: A-law transmit works as follows. The clamped magnitude is divided by 4, giving m. If m < 32, the segment is 0 and the mantissa is m[4:1]. Otherwise the segment is the highest set bit position minus 4 and the mantissa is the four bits below it. The code is {positive, segment, mantissa} XOR 0x55.
- R9: A received µ-law code c is expanded as follows. Let i = ~c, with segment i[6:4] and mantissa i[3:0]. The result is ±2·(((2·mantissa+33)<<segment) − 33), and it is negative when i[7] is 1.
- R10: A received A-law code c is expanded as follows. Let e = c XOR 0x55. The magnitude is 4·(2·mantissa+1) for segment 0 and 4·((2·mantissa+33)<<(segment−1)) otherwise. The result is positive when e[7] is 1.
- R11: Frame sync seen while a frame is in progress abandons that frame, so no `rx_valid` is produced for it, and starts a new frame from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fsync | input | 1 | Frame sync, sampled on the rising edge |
| mode | input | 2 | Word format: 00/11 linear, 01 µ-law, 10 A-law |
| sdin | input | 1 | Serial receive data |
| sdout | output | 1 | Serial transmit data |
| tx_sample | input | 15 | Linear transmit sample, two's complement |
| tx_valid | input | 1 | Loads `tx_sample` into the holding register |
| rx_sample | output | 15 | Linear received sample, two's complement |
| rx_valid | output | 1 | One-cycle strobe marking a new `rx_sample` |

## Verification
Counting from the rising edge k that sees frame sync, transmit bit j is due after edge k+j and the idle zero after edge k+N. Each receive bit must be in place before the edge that samples it, and the decoded sample with its strobe is due after edge k+N+1. The bench changes inputs and reads outputs only on falling edges, and it counts falling edges from the one after edge k. This puts every read in the half cycle after the edge where the value is due. It also checks that the strobe is absent one cycle before that point and gone one cycle after it.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int LIN_W  = 15;
  localparam int CODE_W = 8;
  localparam int MAG_W  = LIN_W - 1;
  localparam int CNT_W  = $clog2(LIN_W + 1);

  localparam logic [MAG_W-1:0] MAG_MAX  = {MAG_W{1'b1}};
  localparam logic [MAG_W-1:0] MU_CLIP  = 14'd8158;
  localparam logic [MAG_W-1:0] MU_BIAS  = 14'd33;
  localparam logic [CODE_W-1:0] A_TOGGLE = 8'h55;

  typedef enum logic [1:0] {
    FMT_LIN  = 2'b00,
    FMT_ULAW = 2'b01,
    FMT_ALAW = 2'b10,
    FMT_LIN2 = 2'b11
  } fmt_e;

  function automatic logic [CNT_W-1:0] frame_len(input fmt_e f);
    if (f == FMT_ULAW || f == FMT_ALAW) frame_len = CNT_W'(CODE_W);
    else                                frame_len = CNT_W'(LIN_W);
  endfunction

  // sign-magnitude split with clamp of the most negative value
  function automatic logic [MAG_W-1:0] lin_mag(input logic [LIN_W-1:0] x);
    logic [LIN_W-1:0] a;
    a = x[LIN_W-1] ? -x : x;
    lin_mag = a[LIN_W-1] ? MAG_MAX : a[MAG_W-1:0];
  endfunction

  function automatic logic [CODE_W-1:0] mu_compress(input logic [LIN_W-1:0] x);
    logic [MAG_W-1:0] half, b;
    logic [2:0] seg;
    logic [3:0] man;
    half = lin_mag(x) >> 1;
    b    = ((half > MU_CLIP) ? MU_CLIP : half) + MU_BIAS;
    seg  = 3'd0;
    for (int i = 5; i <= 12; i++) begin
      if (b[i]) seg = 3'(i - 5);
    end
    man = 4'(b >> ({1'b0, seg} + 4'd1));
    mu_compress = ~{x[LIN_W-1], seg, man};
  endfunction

  function automatic logic [CODE_W-1:0] a_compress(input logic [LIN_W-1:0] x);
    logic [MAG_W-1:0] q;
    logic [2:0] seg;
    logic [3:0] man;
    q   = lin_mag(x) >> 2;
    seg = 3'd0;
    for (int i = 5; i <= 11; i++) begin
      if (q[i]) seg = 3'(i - 4);
    end
    man = (seg == 3'd0) ? 4'(q >> 1) : 4'(q >> seg);
    a_compress = {~x[LIN_W-1], seg, man} ^ A_TOGGLE;
  endfunction

  function automatic logic [LIN_W-1:0] mu_expand(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] i;
    logic [MAG_W-1:0]  m;
    i = ~c;
    m = ((MAG_W'({i[3:0], 1'b0}) + MU_BIAS) << i[6:4]) - MU_BIAS;
    m = m << 1;
    mu_expand = i[7] ? -{1'b0, m} : {1'b0, m};
  endfunction

  function automatic logic [LIN_W-1:0] a_expand(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] e;
    logic [MAG_W-1:0]  m;
    e = c ^ A_TOGGLE;
    if (e[6:4] == 3'd0) m = MAG_W'({e[3:0], 1'b1});
    else                m = (MAG_W'({e[3:0], 1'b0}) + MU_BIAS) << (e[6:4] - 3'd1);
    m = m << 2;
    a_expand = e[7] ? {1'b0, m} : -{1'b0, m};
  endfunction

endpackage

// File: rtl/pcm_frame_ctl.sv
module pcm_frame_ctl
  import pcm_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fsync,
  input  fmt_e  mode_i,
  output fmt_e  fmt_o,
  output logic  active_o,
  output logic  bit_edge_o,
  output logic  last_edge_o,
  output logic  done_o
);

  logic             active_q, active_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  fmt_e             fmt_q, fmt_n;
  logic             done_q, done_n;
  logic [CNT_W-1:0] len;
  logic             bit_edge, last_edge;

  always_comb begin
    len       = frame_len(fmt_q);
    bit_edge  = active_q & ~fsync;
    last_edge = bit_edge & (cnt_q == len);
    active_n  = active_q;
    cnt_n     = cnt_q;
    fmt_n     = fmt_q;
    done_n    = last_edge;
    if (fsync) begin
      active_n = 1'b1;
      cnt_n    = CNT_W'(1);
      fmt_n    = mode_i;
    end else if (bit_edge) begin
      if (last_edge) active_n = 1'b0;
      else           cnt_n    = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      fmt_q    <= FMT_LIN;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_n;
      cnt_q    <= cnt_n;
      fmt_q    <= fmt_n;
      done_q   <= done_n;
    end
  end

  assign fmt_o       = fmt_q;
  assign active_o    = active_q;
  assign bit_edge_o  = bit_edge;
  assign last_edge_o = last_edge;
  assign done_o      = done_q;

  // R3: inside a frame the slot counter stays within the frame length
  a_r3_cnt_window: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= len));

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LIN_W-1:0] tx_sample,
  input  logic             tx_valid,
  input  logic             load,
  input  logic             shift,
  input  logic             last,
  input  fmt_e             fmt,
  output logic             sdout
);

  logic [LIN_W-1:0] hold_q, hold_n;
  logic [LIN_W-1:0] sh_q, sh_n;
  logic             out_q, out_n;
  logic [LIN_W-1:0] word;

  always_comb begin
    case (fmt)
      FMT_ULAW: word = {mu_compress(hold_q), {(LIN_W-CODE_W){1'b0}}};
      FMT_ALAW: word = {a_compress(hold_q),  {(LIN_W-CODE_W){1'b0}}};
      default:  word = hold_q;
    endcase
  end

  always_comb begin
    hold_n = tx_valid ? tx_sample : hold_q;
    sh_n   = sh_q;
    out_n  = out_q;
    if (load) begin
      sh_n  = {word[LIN_W-2:0], 1'b0};
      out_n = word[LIN_W-1];
    end else if (shift) begin
      sh_n  = {sh_q[LIN_W-2:0], 1'b0};
      out_n = last ? 1'b0 : sh_q[LIN_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sh_q   <= '0;
      out_q  <= 1'b0;
    end else begin
      hold_q <= hold_n;
      sh_q   <= sh_n;
      out_q  <= out_n;
    end
  end

  assign sdout = out_q;

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sdin,
  input  logic             shift,
  input  logic             done,
  input  fmt_e             fmt,
  output logic [LIN_W-1:0] rx_sample,
  output logic             rx_valid
);

  logic [LIN_W-1:0] sh_q, sh_n;
  logic [LIN_W-1:0] smp_q, smp_n;
  logic             vld_q;
  logic [LIN_W-1:0] lin;

  always_comb begin
    case (fmt)
      FMT_ULAW: lin = mu_expand(sh_q[CODE_W-1:0]);
      FMT_ALAW: lin = a_expand(sh_q[CODE_W-1:0]);
      default:  lin = sh_q;
    endcase
    sh_n  = shift ? {sh_q[LIN_W-2:0], sdin} : sh_q;
    smp_n = done ? lin : smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      smp_q <= smp_n;
      vld_q <= done;
    end
  end

  assign rx_sample = smp_q;
  assign rx_valid  = vld_q;

  // R5: the strobe never lasts longer than one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fsync,
  input  logic [1:0]            mode,
  input  logic                  sdin,
  output logic                  sdout,
  input  logic [LIN_W-1:0]      tx_sample,
  input  logic                  tx_valid,
  output logic [LIN_W-1:0]      rx_sample,
  output logic                  rx_valid
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fmt_e frm_fmt;
  logic frm_active, frm_bit, frm_last, frm_done;

  pcm_frame_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .fsync       (fsync),
    .mode_i      (fmt_e'(mode)),
    .fmt_o       (frm_fmt),
    .active_o    (frm_active),
    .bit_edge_o  (frm_bit),
    .last_edge_o (frm_last),
    .done_o      (frm_done)
  );

  pcm_tx_path u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tx_sample (tx_sample),
    .tx_valid  (tx_valid),
    .load      (fsync),
    .shift     (frm_bit),
    .last      (frm_last),
    .fmt       (fmt_e'(mode)),
    .sdout     (sdout)
  );

  pcm_rx_path u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sdin      (sdin),
    .shift     (frm_bit),
    .done      (frm_done),
    .fmt       (frm_fmt),
    .rx_sample (rx_sample),
    .rx_valid  (rx_valid)
  );

  // R4: outside a frame the serial output is held low
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    !frm_active |-> (sdout == 1'b0));

  // R5: a received strobe only follows a completed frame
  a_r5_valid_after_done: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_valid |-> $past(frm_done));

endmodule

// File: tb/pcm_voice_port_tb.sv
module pcm_voice_port_tb;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        sdin = 1'b0;
  logic        sdout;
  logic [14:0] tx_sample = '0;
  logic        tx_valid = 1'b0;
  logic [14:0] rx_sample;
  logic        rx_valid;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  pcm_voice_port u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .mode(mode), .sdin(sdin),
    .sdout(sdout), .tx_sample(tx_sample), .tx_valid(tx_valid),
    .rx_sample(rx_sample), .rx_valid(rx_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference models written from the requirement text
  function automatic logic [7:0] ref_mu(input logic [14:0] x);
    int v = $signed(x);
    int m = (v < 0) ? -v : v;
    int s = 0;
    int man;
    if (m > 16383) m = 16383;
    m = m / 2;
    if (m > 8158) m = 8158;
    m = m + 33;
    while (s < 7 && m >= (64 << s)) s++;
    man = (m >> (s + 1)) & 15;
    return ~{(v < 0), 3'(s), 4'(man)};
  endfunction

  function automatic logic [7:0] ref_a(input logic [14:0] x);
    int v = $signed(x);
    int m = (v < 0) ? -v : v;
    int s = 0;
    int man;
    if (m > 16383) m = 16383;
    m = m / 4;
    while (s < 7 && m >= (32 << s)) s++;
    man = (m >> ((s == 0) ? 1 : s)) & 15;
    return {(v >= 0), 3'(s), 4'(man)} ^ 8'h55;
  endfunction

  function automatic logic [14:0] ref_mu_dec(input logic [7:0] c);
    logic [7:0] i = ~c;
    int mag = ((2 * int'(i[3:0]) + 33) * (1 << i[6:4]) - 33) * 2;
    return i[7] ? 15'(-mag) : 15'(mag);
  endfunction

  function automatic logic [14:0] ref_a_dec(input logic [7:0] c);
    logic [7:0] e = c ^ 8'h55;
    int mag;
    if (e[6:4] == 0) mag = 2 * int'(e[3:0]) + 1;
    else             mag = (2 * int'(e[3:0]) + 33) * (1 << (e[6:4] - 1));
    mag = mag * 4;
    return e[7] ? 15'(mag) : 15'(-mag);
  endfunction

  task automatic load_tx(input logic [14:0] v);
    @(negedge clk); tx_sample = v; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  // Runs one frame: sync seen at edge k, bits read after edges k..k+N-1,
  // idle zero after k+N, strobe after k+N+1 (R3, R4, R5).
  task automatic do_frame(input logic [1:0] m, input logic [14:0] rxw,
                          input int upd_at, input logic [14:0] upd_val,
                          output logic [14:0] txw, output logic [14:0] rxo);
    int n = (m == 2'b01 || m == 2'b10) ? 8 : 15;
    int early = 0;
    @(negedge clk); mode = m; fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
    txw = '0;
    for (int j = 0; j < n; j++) begin
      if (j > 0) @(negedge clk);
      txw = {txw[13:0], sdout};
      if (rx_valid) early++;
      sdin = rxw[n-1-j];
      if (j == upd_at) begin tx_sample = upd_val; tx_valid = 1'b1; end
      else tx_valid = 1'b0;
    end
    @(negedge clk); tx_valid = 1'b0;
    check(sdout == 1'b0, "R4", "sdout after last bit", sdout, 0);
    check(early == 0 && rx_valid == 1'b0, "R5", "no strobe before k+N+1", early + rx_valid, 0);
    @(negedge clk);
    check(sdout == 1'b0, "R4", "sdout idle", sdout, 0);
    check(rx_valid == 1'b1, "R5", "strobe after k+N+1", rx_valid, 1);
    rxo = rx_sample;
    @(negedge clk);
    check(rx_valid == 1'b0, "R5", "strobe one cycle", rx_valid, 0);
    check(rx_sample == rxo, "R5", "sample held", rx_sample, rxo);
  endtask

  task automatic t_reset();
    #(CLK_P * 2);
    check(sdout == 0 && rx_valid == 0 && rx_sample == 0, "R1", "outputs in reset",
          {sdout, rx_valid, rx_sample}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sdout == 0 && rx_valid == 0 && rx_sample == 0, "R1", "outputs after reset",
          {sdout, rx_valid, rx_sample}, 0);
  endtask

  task automatic t_linear();
    logic [14:0] t, r;
    load_tx(15'h5A3C);
    do_frame(2'b00, 15'h6B21, -1, '0, t, r);
    check(t == 15'h5A3C, "R3", "linear tx word", t, 15'h5A3C);
    check(r == 15'h6B21, "R5", "linear rx word", r, 15'h6B21);
    load_tx(15'h4001);
    do_frame(2'b11, 15'h7FFE, -1, '0, t, r);
    check(t == 15'h4001, "R2", "mode 11 sends 15 bits", t, 15'h4001);
    check(r == 15'h7FFE, "R2", "mode 11 takes 15 bits", r, 15'h7FFE);
  endtask

  task automatic t_mu_tx();
    logic [14:0] vals [6] = '{15'd0, 15'd1000, -15'sd1000, 15'h3FFF, 15'h4000, 15'd17};
    logic [14:0] t, r;
    foreach (vals[i]) begin
      load_tx(vals[i]);
      do_frame(2'b01, 15'h00FF, -1, '0, t, r);
      check(t[7:0] == ref_mu(vals[i]), "R7", "ulaw tx code", t[7:0], ref_mu(vals[i]));
    end
  endtask

  task automatic t_a_tx();
    logic [14:0] vals [6] = '{15'd0, 15'd1000, -15'sd1000, 15'h3FFF, 15'h4000, 15'd130};
    logic [14:0] t, r;
    foreach (vals[i]) begin
      load_tx(vals[i]);
      do_frame(2'b10, 15'h00D5, -1, '0, t, r);
      check(t[7:0] == ref_a(vals[i]), "R8", "alaw tx code", t[7:0], ref_a(vals[i]));
    end
  endtask

  task automatic t_mu_rx();
    logic [7:0] codes [5] = '{8'hFF, 8'h00, 8'h80, 8'h7F, 8'h35};
    logic [14:0] t, r;
    foreach (codes[i]) begin
      do_frame(2'b01, {7'd0, codes[i]}, -1, '0, t, r);
      check(r == ref_mu_dec(codes[i]), "R9", "ulaw rx expand", r, ref_mu_dec(codes[i]));
    end
  endtask

  task automatic t_a_rx();
    logic [7:0] codes [5] = '{8'hD5, 8'h55, 8'hAA, 8'h2A, 8'hF3};
    logic [14:0] t, r;
    foreach (codes[i]) begin
      do_frame(2'b10, {7'd0, codes[i]}, -1, '0, t, r);
      check(r == ref_a_dec(codes[i]), "R10", "alaw rx expand", r, ref_a_dec(codes[i]));
    end
  endtask

  task automatic t_hold();
    logic [14:0] t, r;
    load_tx(15'h1234);
    do_frame(2'b00, 15'h0001, 4, 15'h6DDB, t, r);
    check(t == 15'h1234, "R6", "mid-frame load ignored", t, 15'h1234);
    do_frame(2'b00, 15'h0002, -1, '0, t, r);
    check(t == 15'h6DDB, "R6", "next frame uses new sample", t, 15'h6DDB);
  endtask

  task automatic t_resync();
    logic [14:0] t, r;
    int seen = 0;
    load_tx(15'h2AAA);
    @(negedge clk); mode = 2'b00; fsync = 1'b1;
    @(negedge clk); fsync = 1'b0;
    for (int j = 0; j < 5; j++) begin
      sdin = 1'b1;
      @(negedge clk);
      if (rx_valid) seen++;
    end
    do_frame(2'b00, 15'h0F0F, -1, '0, t, r);
    check(seen == 0, "R11", "no strobe for abandoned frame", seen, 0);
    check(t == 15'h2AAA, "R11", "restarted tx word", t, 15'h2AAA);
    check(r == 15'h0F0F, "R11", "restarted rx word", r, 15'h0F0F);
  endtask

  initial begin
    t_reset();
    t_linear();
    t_mu_tx();
    t_a_tx();
    t_mu_rx();
    t_a_rx();
    t_hold();
    t_resync();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule